// File: doc/BRIEF.md
# DDR3 Write Burst Lane Sequencer

This block runs in the logic clock domain of a memory interface whose memory clock is twice as fast, so every output serializer takes a 4-bit parallel word each logic cycle. For a 16-bit data bus split into two byte lanes, it turns a write command and its 8-beat burst of data and byte masks into the parallel words for the data lines, the mask lines, the data strobes and the tristate controls. The words are timed so that the strobe preamble, the burst and the postamble reach the bus at the memory-clock positions that the CAS write latency requires.

A write command is presented as a one-cycle `wr_valid` pulse with the whole burst attached. The command path outside the block places the command in the first memory clock of the logic cycle that follows the pulse, and the lane words use the same reference. Word bit 0 is serialized first. The quarter-period shift of the data against the strobe comes from a separate serializer clock, so the block emits data and strobe words on the same beat grid. Commands arrive at the 2T command rate and never less than two logic cycles (four memory clocks) apart.

Top module: `ddr_wr_lane_seq`

## Requirements
- R1: While reset is asserted and after its release with no command, every output word is zero, so all lines are released (tristate enable 0 means released, 1 means driven).
- R2: For a command pulsed in logic cycle T, the word presented in cycle T+1+m carries relative beats 4m..4m+3 (bit j is beat 4m+j), and the first burst beat, where the strobe first goes high, is relative beat 2*CWL.
- R3: Burst beat b on data line n comes from `wr_data[b*DQ_W+n]` and appears at `dq_par[n*4+j]`. Data bits are zero on every beat outside a burst.
- R4: The mask for lane l on burst beat b comes from `wr_mask[b*LANES+l]` (1 means the byte is not written) and appears at `dm_par[l*4+j]`. It is zero outside a burst.
- R5: During a burst the strobe is 1 on even burst beats and 0 on odd burst beats.
- R6: The two beats before the first burst beat (one memory clock) drive the strobe 0 with both enables set.
- R7: The beat after the last burst beat (half a memory clock) drives the strobe 0 with both enables set.
- R8: Each lane's data and strobe enables are 1 only on beats inside the window that runs from the preamble through the postamble of some command, and 0 on all other beats.
- R9: With an odd CWL the burst starts at bit 2 of a word and straddles a logic-cycle boundary, with the beat order unchanged.
- R10: Two commands exactly two logic cycles apart produce an unbroken strobe: burst beats take priority over the other command's preamble or postamble, so no driven-low pair or released beat falls between the bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock (half the memory clock rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | One-cycle write command pulse |
| wr_data | input | BURST*DQ_W (128) | Burst data, beat b at bits [b*DQ_W +: DQ_W] |
| wr_mask | input | BURST*LANES (16) | Byte masks, beat b lane l at bit b*LANES+l |
| dq_par | output | DQ_W*4 (64) | Data serializer words, line n at bits [n*4 +: 4] |
| dm_par | output | LANES*4 (8) | Mask serializer words per lane |
| dqs_par | output | LANES*4 (8) | Strobe serializer words per lane |
| dq_oe_par | output | LANES*4 (8) | Data and mask line drive enables per lane |
| dqs_oe_par | output | LANES*4 (8) | Strobe drive enables per lane |

## Verification
The hardest case to reach is the overlap of two command windows. When writes are exactly two cycles apart, the preamble of the later command falls on burst beats of the earlier one. When they are three cycles apart, a single released beat sits between the postamble and the next preamble. Random stimulus issues commands with a high probability as soon as the spacing rule allows, so both spacings occur many times, and a directed back-to-back pair checks the unbroken strobe word by word. A second instance with an odd write latency gets the same stimulus, which covers bursts that straddle word boundaries.

// File: rtl/ddr_wr_pkg.sv
package ddr_wr_pkg;

    localparam int BEATS_PER_WORD = 4;
    localparam int BURST_BEATS    = 8;

    typedef enum logic [1:0] {
        BK_IDLE  = 2'd0,
        BK_AMBLE = 2'd1,
        BK_BURST = 2'd2
    } beat_kind_e;

    // Position of a word slot relative to the first burst beat of a command
    // that is 'age' words old.
    function automatic int rel_beat(int age, int slot, int cwl);
        return BEATS_PER_WORD * age + slot - 2 * cwl;
    endfunction

    // Oldest command age whose window (up to the postamble) can still show.
    function automatic int last_age(int cwl);
        return (2 * cwl + BURST_BEATS) / BEATS_PER_WORD;
    endfunction

endpackage

// File: rtl/ddr_wr_hist.sv
module ddr_wr_hist #(
    parameter int DEPTH = 5,
    parameter int DW    = 128,
    parameter int MW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [DW-1:0]    in_data,
    input  logic [MW-1:0]    in_mask,
    output logic [DEPTH-1:0] h_valid,
    output logic [DW-1:0]    h_data [DEPTH],
    output logic [MW-1:0]    h_mask [DEPTH]
);

    typedef struct packed {
        logic [DEPTH-1:0]         v;
        logic [DEPTH-1:0][DW-1:0] d;
        logic [DEPTH-1:0][MW-1:0] m;
    } hist_t;

    hist_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.v[0] = in_valid;
        s_d.d[0] = in_data;
        s_d.m[0] = in_mask;
        for (int i = 1; i < DEPTH; i++) begin
            s_d.v[i] = s_q.v[i-1];
            s_d.d[i] = s_q.d[i-1];
            s_d.m[i] = s_q.m[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign h_valid = s_q.v;

    for (genvar g = 0; g < DEPTH; g++) begin : g_out
        assign h_data[g] = s_q.d[g];
        assign h_mask[g] = s_q.m[g];
    end

    // R10: commands are at least two logic cycles (tCCD) apart
    a_r10_min_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> !in_valid);

endmodule

// File: rtl/ddr_wr_beat_map.sv
module ddr_wr_beat_map
    import ddr_wr_pkg::*;
#(
    parameter int CWL  = 6,
    parameter int AGES = 6,
    parameter int AW   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AGES-1:0]  age_valid,
    output beat_kind_e       kind    [BEATS_PER_WORD],
    output logic [AW-1:0]    src_age [BEATS_PER_WORD],
    output logic [2:0]       bidx    [BEATS_PER_WORD]
);

    logic [AGES-1:0] claim [BEATS_PER_WORD];

    always_comb begin
        for (int j = 0; j < BEATS_PER_WORD; j++) begin
            kind[j]    = BK_IDLE;
            src_age[j] = '0;
            bidx[j]    = '0;
            claim[j]   = '0;
            for (int a = 0; a < AGES; a++) begin
                int r;
                r = rel_beat(a, j, CWL);
                if (age_valid[a]) begin
                    if (r >= 0 && r < BURST_BEATS) begin
                        claim[j][a] = 1'b1;
                        kind[j]     = BK_BURST;
                        src_age[j]  = AW'(a);
                        bidx[j]     = 3'(r);
                    end else if ((r == -2 || r == -1 || r == BURST_BEATS) &&
                                 kind[j] != BK_BURST) begin
                        kind[j] = BK_AMBLE;
                    end
                end
            end
        end
    end

    for (genvar g = 0; g < BEATS_PER_WORD; g++) begin : g_chk
        // R10: one command at most owns any burst beat
        a_r10_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(claim[g]));
    end

endmodule

// File: rtl/ddr_wr_lane_pack.sv
module ddr_wr_lane_pack
    import ddr_wr_pkg::*;
#(
    parameter int DQ_W  = 16,
    parameter int LANES = 2,
    parameter int AGES  = 6,
    parameter int AW    = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  beat_kind_e                      kind    [BEATS_PER_WORD],
    input  logic [AW-1:0]                   src_age [BEATS_PER_WORD],
    input  logic [2:0]                      bidx    [BEATS_PER_WORD],
    input  logic [BURST_BEATS*DQ_W-1:0]     age_data [AGES],
    input  logic [BURST_BEATS*LANES-1:0]    age_mask [AGES],
    output logic [DQ_W*BEATS_PER_WORD-1:0]  dq_par,
    output logic [LANES*BEATS_PER_WORD-1:0] dm_par,
    output logic [LANES*BEATS_PER_WORD-1:0] dqs_par,
    output logic [LANES*BEATS_PER_WORD-1:0] dq_oe_par,
    output logic [LANES*BEATS_PER_WORD-1:0] dqs_oe_par
);

    localparam int LANE_W = DQ_W / LANES;
    localparam int LW     = LANES * BEATS_PER_WORD;

    typedef struct packed {
        logic [DQ_W*BEATS_PER_WORD-1:0] dq;
        logic [LW-1:0]                  dm;
        logic [LW-1:0]                  dqs;
        logic [LW-1:0]                  dq_oe;
        logic [LW-1:0]                  dqs_oe;
    } word_t;

    word_t s_d, s_q;

    always_comb begin
        s_d = '0;
        for (int j = 0; j < BEATS_PER_WORD; j++) begin
            case (kind[j])
                BK_BURST: begin
                    for (int n = 0; n < DQ_W; n++) begin
                        s_d.dq[n*BEATS_PER_WORD+j] =
                            age_data[src_age[j]][int'(bidx[j])*DQ_W+n];
                    end
                    for (int l = 0; l < LANES; l++) begin
                        s_d.dm[l*BEATS_PER_WORD+j] =
                            age_mask[src_age[j]][int'(bidx[j])*LANES+l];
                        s_d.dqs[l*BEATS_PER_WORD+j]    = ~bidx[j][0];
                        s_d.dq_oe[l*BEATS_PER_WORD+j]  = 1'b1;
                        s_d.dqs_oe[l*BEATS_PER_WORD+j] = 1'b1;
                    end
                end
                BK_AMBLE: begin
                    for (int l = 0; l < LANES; l++) begin
                        s_d.dq_oe[l*BEATS_PER_WORD+j]  = 1'b1;
                        s_d.dqs_oe[l*BEATS_PER_WORD+j] = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dq_par     = s_q.dq;
    assign dm_par     = s_q.dm;
    assign dqs_par    = s_q.dqs;
    assign dq_oe_par  = s_q.dq_oe;
    assign dqs_oe_par = s_q.dqs_oe;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        for (genvar j = 0; j < BEATS_PER_WORD; j++) begin : g_beat
            logic [LANE_W-1:0] lane_bits;
            for (genvar n = 0; n < LANE_W; n++) begin : g_bit
                assign lane_bits[n] = dq_par[(l*LANE_W+n)*BEATS_PER_WORD+j];
            end
            // R8: released data lines carry no data
            a_r8_dq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
                !dq_oe_par[l*BEATS_PER_WORD+j] |-> (lane_bits == '0));
            // R4: a mask bit only appears on a driven beat
            a_r4_mask_driven: assert property (@(posedge clk) disable iff (!rst_n)
                dm_par[l*BEATS_PER_WORD+j] |-> dq_oe_par[l*BEATS_PER_WORD+j]);
            // R5: a high strobe beat is always driven
            a_r5_strobe_driven: assert property (@(posedge clk) disable iff (!rst_n)
                dqs_par[l*BEATS_PER_WORD+j] |-> dqs_oe_par[l*BEATS_PER_WORD+j]);
        end
    end

endmodule

// File: rtl/ddr_wr_lane_seq.sv
module ddr_wr_lane_seq
    import ddr_wr_pkg::*;
#(
    parameter int DQ_W  = 16,
    parameter int LANES = 2,
    parameter int CWL   = 6
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_valid,
    input  logic [BURST_BEATS*DQ_W-1:0]      wr_data,
    input  logic [BURST_BEATS*LANES-1:0]     wr_mask,
    output logic [DQ_W*BEATS_PER_WORD-1:0]   dq_par,
    output logic [LANES*BEATS_PER_WORD-1:0]  dm_par,
    output logic [LANES*BEATS_PER_WORD-1:0]  dqs_par,
    output logic [LANES*BEATS_PER_WORD-1:0]  dq_oe_par,
    output logic [LANES*BEATS_PER_WORD-1:0]  dqs_oe_par
);

    localparam int MAX_AGE = last_age(CWL);
    localparam int AGES    = MAX_AGE + 1;
    localparam int AW      = (AGES > 1) ? $clog2(AGES) : 1;
    localparam int DW      = BURST_BEATS * DQ_W;
    localparam int MW      = BURST_BEATS * LANES;

    logic [MAX_AGE-1:0] h_valid;
    logic [DW-1:0]      h_data [MAX_AGE];
    logic [MW-1:0]      h_mask [MAX_AGE];

    logic [AGES-1:0]    age_valid;
    logic [DW-1:0]      age_data [AGES];
    logic [MW-1:0]      age_mask [AGES];

    beat_kind_e         kind    [BEATS_PER_WORD];
    logic [AW-1:0]      src_age [BEATS_PER_WORD];
    logic [2:0]         bidx    [BEATS_PER_WORD];

    ddr_wr_hist #(.DEPTH(MAX_AGE), .DW(DW), .MW(MW)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (wr_valid),
        .in_data  (wr_data),
        .in_mask  (wr_mask),
        .h_valid  (h_valid),
        .h_data   (h_data),
        .h_mask   (h_mask)
    );

    assign age_valid   = {h_valid, wr_valid};
    assign age_data[0] = wr_data;
    assign age_mask[0] = wr_mask;
    for (genvar a = 1; a < AGES; a++) begin : g_age
        assign age_data[a] = h_data[a-1];
        assign age_mask[a] = h_mask[a-1];
    end

    ddr_wr_beat_map #(.CWL(CWL), .AGES(AGES), .AW(AW)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .age_valid (age_valid),
        .kind      (kind),
        .src_age   (src_age),
        .bidx      (bidx)
    );

    ddr_wr_lane_pack #(.DQ_W(DQ_W), .LANES(LANES), .AGES(AGES), .AW(AW)) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .kind       (kind),
        .src_age    (src_age),
        .bidx       (bidx),
        .age_data   (age_data),
        .age_mask   (age_mask),
        .dq_par     (dq_par),
        .dm_par     (dm_par),
        .dqs_par    (dqs_par),
        .dq_oe_par  (dq_oe_par),
        .dqs_oe_par (dqs_oe_par)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_strobe_chk
        localparam int B = l * BEATS_PER_WORD;
        // R6: the first driven strobe beat after a released beat is low
        a_r6_first_low_xword: assert property (@(posedge clk) disable iff (!rst_n)
            (dqs_oe_par[B] && !$past(dqs_oe_par[B+3])) |-> !dqs_par[B]);
        // R7: a high strobe beat is never the last driven beat
        a_r7_high_then_driven: assert property (@(posedge clk) disable iff (!rst_n)
            (dqs_oe_par[B+3] && dqs_par[B+3]) |=> dqs_oe_par[B]);
        for (genvar j = 1; j < BEATS_PER_WORD; j++) begin : g_in_word
            // R6: window opening inside a word starts low
            a_r6_first_low: assert property (@(posedge clk) disable iff (!rst_n)
                (dqs_oe_par[B+j] && !dqs_oe_par[B+j-1]) |-> !dqs_par[B+j]);
            // R7: window closing inside a word ends low
            a_r7_last_low: assert property (@(posedge clk) disable iff (!rst_n)
                (dqs_oe_par[B+j-1] && !dqs_oe_par[B+j]) |-> !dqs_par[B+j-1]);
        end
    end

endmodule

// File: tb/ddr_wr_lane_seq_tb.sv
`timescale 1ns/1ps
module ddr_wr_lane_seq_tb;

    localparam int CLK_P = 4;
    localparam int NCYC  = 3000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 1'b0;
    logic [127:0] wr_data = '0;
    logic [15:0]  wr_mask = '0;

    logic [63:0] dq_a, dq_b;
    logic [7:0]  dm_a, dqs_a, doe_a, soe_a;
    logic [7:0]  dm_b, dqs_b, doe_b, soe_b;

    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    int ncmd = 0;
    int last_t = -100;
    int      cmd_t [0:4095];
    logic [127:0] cmd_d [0:4095];
    logic [15:0]  cmd_m [0:4095];

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    ddr_wr_lane_seq #(.DQ_W(16), .LANES(2), .CWL(6)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_mask(wr_mask), .dq_par(dq_a), .dm_par(dm_a), .dqs_par(dqs_a),
        .dq_oe_par(doe_a), .dqs_oe_par(soe_a));

    ddr_wr_lane_seq #(.DQ_W(16), .LANES(2), .CWL(5)) u_dut_odd (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_mask(wr_mask), .dq_par(dq_b), .dm_par(dm_b), .dqs_par(dqs_b),
        .dq_oe_par(doe_b), .dqs_oe_par(soe_b));

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s cyc=%0d got=%h exp=%h", tag, cyc, got, exp);
        end
    endtask

    // Model of the requirements: classify every beat from the command log.
    task automatic check_dut(input int cwl, input bit odd,
                             input logic [63:0] dq, input logic [7:0] dm,
                             input logic [7:0] dqs, input logic [7:0] doe,
                             input logic [7:0] soe);
        for (int j = 0; j < 4; j++) begin
            bit bur = 0, pre = 0, post = 0;
            int src = 0, b = 0;
            for (int k = ncmd - 1; k >= 0; k--) begin
                int r;
                if (cmd_t[k] < cyc - 12) break;
                r = 4 * (cyc - cmd_t[k] - 1) + j - 2 * cwl;
                if (r >= 0 && r <= 7) begin bur = 1; src = k; b = r; end
                else if (r == -2 || r == -1) pre = 1;
                else if (r == 8) post = 1;
            end
            for (int l = 0; l < 2; l++) begin
                logic [7:0] g_dq, e_dq;
                for (int i = 0; i < 8; i++) begin
                    g_dq[i] = dq[(l*8+i)*4+j];
                    e_dq[i] = bur ? cmd_d[src][b*16+l*8+i] : 1'b0;
                end
                chk(odd ? "R9 data" : "R3 data", 32'(g_dq), 32'(e_dq));
                chk("R4 mask", 32'(dm[l*4+j]), bur ? 32'(cmd_m[src][b*2+l]) : 32'd0);
                if (bur)       chk("R5 strobe", 32'(dqs[l*4+j]), 32'((b % 2) == 0));
                else if (pre)  chk("R6 preamble", 32'(dqs[l*4+j]), 32'd0);
                else if (post) chk("R7 postamble", 32'(dqs[l*4+j]), 32'd0);
                else           chk("R8 idle strobe", 32'(dqs[l*4+j]), 32'd0);
                chk("R8 enables", 32'({doe[l*4+j], soe[l*4+j]}),
                    (bur || pre || post) ? 32'd3 : 32'd0);
            end
        end
    endtask

    task automatic issue();
        cmd_t[ncmd] = cyc;
        cmd_d[ncmd] = {$urandom, $urandom, $urandom, $urandom};
        cmd_m[ncmd] = 16'($urandom);
        wr_data  = cmd_d[ncmd];
        wr_mask  = cmd_m[ncmd];
        wr_valid = 1'b1;
        last_t   = cyc;
        ncmd++;
    endtask

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset", {dq_a[31:0]}, 32'd0);
        chk("R1 reset", {dq_a[63:32]}, 32'd0);
        chk("R1 reset", {dm_a, dqs_a, doe_a, soe_a}, 32'd0);
        chk("R1 reset", {dm_b, dqs_b, doe_b, soe_b}, 32'd0);
        rst_n = 1'b1;
        for (int n = 0; n < NCYC; n++) begin
            @(negedge clk);
            check_dut(6, 1'b0, dq_a, dm_a, dqs_a, doe_a, soe_a);
            check_dut(5, 1'b1, dq_b, dm_b, dqs_b, doe_b, soe_b);
            // directed: single command at cycle 5
            if (cyc == 3) chk("R1 idle after reset", {dqs_a, doe_a, soe_a, dm_a}, 32'd0);
            if (cyc == 8) begin
                chk("R2 preamble word", {28'd0, soe_a[3:0]}, 32'hC);
                chk("R2 preamble word", {28'd0, dqs_a[3:0]}, 32'h0);
                chk("R9 odd straddle", {28'd0, dqs_b[3:0]}, 32'h4);
                chk("R9 odd straddle", {28'd0, soe_b[3:0]}, 32'hF);
            end
            if (cyc == 9) chk("R2 first edge", {28'd0, dqs_a[3:0]}, 32'h5);
            // directed: back-to-back at cycles 30 and 32
            if (cyc >= 34 && cyc <= 37) begin
                chk("R10 continuous strobe", {24'd0, dqs_a}, 32'h55);
                chk("R10 continuous enable", {24'd0, soe_a}, 32'hFF);
            end
            if (cyc == 38) chk("R10 single postamble", {24'd0, soe_a}, 32'h11);
            wr_valid = 1'b0;
            if (cyc == 5 || cyc == 30 || cyc == 32) issue();
            else if (cyc >= 60 && cyc - last_t >= 2 && ($urandom % 100) < 55) issue();
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule